// File: doc/BRIEF.md
# Banked Extended-RAM Burst Access Port

This block gives a host an indirect path into a large extended RAM placed behind a small banked register file. The host talks to it over a plain synchronous register bus. That bus has an 8-bit offset, 8-bit write and read data, and one-cycle write and read strobes. A select bit in the always-visible control register switches the upper part of the register space between two views. In the first view it is a 64-byte general-purpose RAM. In the second view it holds the pointer and data-port registers of the extended RAM.

To use the extended RAM, the host first sets the bank select bit. It then loads the RAM pointer through a low-byte and a high-byte register, and moves bytes through a single data-port register. When the burst enable bit is set, every data-port read or write advances the pointer by one after the access. A run of consecutive data-port accesses therefore walks through the RAM without reloading the pointer. The RAM depth is a build parameter of 2048, 4096 or 8192 bytes. The pointer is exactly as wide as the depth needs, so it wraps to zero after the last byte.

Top module: `xram_port`

## Requirements
- R1: After reset, bus_rdata is 0x00, and the control register at 0x0A, the extended control register at 0x4A and both pointer bytes all read back 0x00.
- R2: A read strobe sampled at a clock edge puts the addressed byte on bus_rdata after that edge. The value holds until the next accepted read.
- R3: Offset 0x0A is an 8-bit read/write register in both views, and its bit 4 selects the extended view. Offsets 0x40 to 0x7F reach the extended registers only while that bit is 1.
- R4: In the extended view, 0x50 holds pointer bits 7:0 and 0x51 holds the pointer bits above 7. Pointer bits above the configured depth are dropped on write and read back as 0. Reads of either byte return the current pointer, including any burst increments.
- R5: In the extended view, a write to 0x53 stores the byte at the pointer, and a read of 0x53 returns the byte at the pointer.
- R6: When bit 5 of 0x4A is 1, every data-port read or write increments the pointer by one after the access.
- R7: When bit 5 of 0x4A is 0, data-port accesses leave the pointer unchanged.
- R8: A burst increment from the last RAM byte (depth minus one) wraps the pointer to 0.
- R9: Bits 5 and 4 of 0x4A are read/write storage, whether or not they have any effect. All other bits of 0x4A read as 0.
- R10: With bit 4 of 0x0A clear, offsets 0x40 to 0x7F address a 64-byte general-purpose RAM indexed by offset bits 5:0. That RAM is separate from the pointer and the extended RAM.
- R11: Offsets that are not mapped read as 0x00, and writes to them change nothing. Examples are 0x00 and, in the extended view, 0x52.
- R12: When the read and write strobes are both high in the same cycle, the write takes place and the read is ignored, so bus_rdata keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and storage clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, registered |

## Verification
Every result of this block is due one clock edge after the strobe that causes it. Read data appears on bus_rdata after the edge that samples the read strobe. A pointer load or a burst increment takes effect at the edge of the access that causes it, so the earliest later read of a pointer byte already shows the new value. The bench changes strobes on the falling edge and drops them after one cycle. It samples bus_rdata at the next falling edge, which is half a cycle after the edge that registered the result. Idle cycles are left between accesses, so a check can never see a result that has not yet settled.

// File: rtl/xram_pkg.sv
// Package: shared offsets, bit positions and types for the banked
// extended-RAM access port. Assumes an 8-bit register bus.
package xram_pkg;

    // Offsets decoded by the port (neighbour software depends on these)
    localparam logic [7:0] OFS_CTLA  = 8'h0A;
    localparam logic [7:0] OFS_EXTC  = 8'h4A;
    localparam logic [7:0] OFS_PLO   = 8'h50;
    localparam logic [7:0] OFS_PHI   = 8'h51;
    localparam logic [7:0] OFS_PORT  = 8'h53;

    // Upper window shared between the general RAM and the extended registers
    localparam logic [1:0] WIN_TAG   = 2'b01;   // offset bits 7:6 for 0x40..0x7F

    localparam int BANK_BIT  = 4;   // bit of 0x0A selecting the extended view
    localparam int BURST_BIT = 5;   // bit of 0x4A enabling auto-increment
    localparam int SPARE_BIT = 4;   // bit of 0x4A kept as plain storage

    localparam int GP_DEPTH  = 64;
    localparam int GP_AW     = $clog2(GP_DEPTH);

    // One select line per addressable target
    typedef struct packed {
        logic ctla;
        logic extc;
        logic plo;
        logic phi;
        logic port;
        logic gp;
    } xsel_t;

    // Source of the registered read data
    typedef enum logic [1:0] {
        RS_REG  = 2'd0,
        RS_XRAM = 2'd1,
        RS_GP   = 2'd2
    } rsrc_t;

endpackage

// File: rtl/xram_decode.sv
// Module: xram_decode
// Combinational offset decoder. Turns a bus offset and the current bank
// view into at most one select line. Assumes the offset is stable in the
// strobe cycle; strobes are qualified outside this module.
module xram_decode
    import xram_pkg::*;
(
    input  logic [7:0] addr,
    input  logic       bank,
    output xsel_t      sel
);

    logic in_win;

    // Window test: offsets 0x40..0x7F
    always_comb in_win = (addr[7:6] == WIN_TAG);

    // Select generation: the extended registers only in the extended view
    always_comb begin
        sel      = '0;
        sel.ctla = (addr == OFS_CTLA);
        sel.gp   = in_win && !bank;
        sel.extc = bank && (addr == OFS_EXTC);
        sel.plo  = bank && (addr == OFS_PLO);
        sel.phi  = bank && (addr == OFS_PHI);
        sel.port = bank && (addr == OFS_PORT);
    end

endmodule

// File: rtl/xram_ptr.sv
// Module: xram_ptr
// RAM address pointer. The low byte and the high part load separately
// from the bus, and a step pulse post-increments the pointer modulo
// 2**AW. Assumes AW lies between 9 and 16, and that a load and a step
// never fall in the same cycle (they come from different offsets).
module xram_ptr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic          step,
    input  logic [7:0]    wdata,
    output logic [AW-1:0] ptr
);

    localparam int HW = AW - 8;

    logic [AW-1:0] ptr_nxt;

    // Next-pointer selection: load low, load high, or increment
    always_comb begin
        ptr_nxt = ptr;
        if (ld_lo)
            ptr_nxt[7:0] = wdata;
        else if (ld_hi)
            ptr_nxt[AW-1:8] = wdata[HW-1:0];
        else if (step)
            ptr_nxt = ptr + AW'(1);
    end

    // Pointer register
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nxt;
    end

endmodule

// File: rtl/xram_store.sv
// Module: xram_store
// Single-port byte RAM with a synchronous, registered read. The read
// register changes only on a read enable, so it holds between reads.
// The array has no reset; only the read register is cleared.
module xram_store #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    // Array write port
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Registered read port, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[addr];
    end

endmodule

// File: rtl/xram_port.sv
// Module: xram_port (top)
// Banked access port: a control register with a bank-select bit, an
// extended control register holding the burst enable, a RAM pointer
// reached through two byte registers, and a data port into an extended
// RAM of XRAM_DEPTH bytes. In the base view, the upper window is a
// 64-byte general RAM. Read data is registered and appears one cycle
// after the read strobe. Assumes XRAM_DEPTH is a power of two from 512
// to 65536; a simultaneous read and write counts as a write only.
module xram_port
    import xram_pkg::*;
#(
    parameter int XRAM_DEPTH = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_wr,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata
);

    localparam int AW = $clog2(XRAM_DEPTH);

    xsel_t         sel;
    logic [7:0]    ctla_q;
    logic [1:0]    extc_q;        // {burst, spare}
    logic          bank_on;
    logic          burst_on;
    logic          wr_ok;
    logic          rd_ok;
    logic          dp_acc;
    logic [AW-1:0] ptr_q;
    logic [15:0]   ptr_wide;
    logic [7:0]    reg_val;
    logic [7:0]    reg_q;
    rsrc_t         rsrc_q;
    logic [7:0]    xram_rd;
    logic [7:0]    gp_rd;

    // Current view and burst enable taken from the stored control bits
    always_comb begin
        bank_on  = ctla_q[BANK_BIT];
        burst_on = extc_q[1];
    end

    // Strobe qualification: a write wins over a read in the same cycle
    always_comb begin
        wr_ok  = bus_wr;
        rd_ok  = bus_rd && !bus_wr;
        dp_acc = sel.port && (wr_ok || rd_ok);
    end

    xram_decode u_dec (
        .addr (bus_addr),
        .bank (bank_on),
        .sel  (sel)
    );

    // Control register, always visible at its offset
    always_ff @(posedge clk) begin
        if (!rst_n)                 ctla_q <= '0;
        else if (wr_ok && sel.ctla) ctla_q <= bus_wdata;
    end

    // Extended control register: only the burst and spare bits are stored
    always_ff @(posedge clk) begin
        if (!rst_n)                 extc_q <= '0;
        else if (wr_ok && sel.extc) extc_q <= {bus_wdata[BURST_BIT], bus_wdata[SPARE_BIT]};
    end

    xram_ptr #(
        .AW (AW)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (wr_ok && sel.plo),
        .ld_hi (wr_ok && sel.phi),
        .step  (dp_acc && burst_on),
        .wdata (bus_wdata),
        .ptr   (ptr_q)
    );

    xram_store #(
        .DEPTH (XRAM_DEPTH),
        .AW    (AW)
    ) u_xram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok && sel.port),
        .re    (rd_ok && sel.port),
        .addr  (ptr_q),
        .wdata (bus_wdata),
        .rdata (xram_rd)
    );

    xram_store #(
        .DEPTH (GP_DEPTH),
        .AW    (GP_AW)
    ) u_gp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok && sel.gp),
        .re    (rd_ok && sel.gp),
        .addr  (bus_addr[GP_AW-1:0]),
        .wdata (bus_wdata),
        .rdata (gp_rd)
    );

    // Register read value; unmapped offsets give zero
    always_comb begin
        ptr_wide = 16'(ptr_q);
        reg_val  = '0;
        if (sel.ctla) reg_val = ctla_q;
        if (sel.extc) reg_val = 8'((extc_q[1] << BURST_BIT) | (extc_q[0] << SPARE_BIT));
        if (sel.plo)  reg_val = ptr_wide[7:0];
        if (sel.phi)  reg_val = ptr_wide[15:8];
    end

    // Read capture: remember the source and any register value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsrc_q <= RS_REG;
            reg_q  <= '0;
        end else if (rd_ok) begin
            reg_q <= reg_val;
            if (sel.port)    rsrc_q <= RS_XRAM;
            else if (sel.gp) rsrc_q <= RS_GP;
            else             rsrc_q <= RS_REG;
        end
    end

    // Output selection from the captured source
    always_comb begin
        case (rsrc_q)
            RS_XRAM: bus_rdata = xram_rd;
            RS_GP:   bus_rdata = gp_rd;
            default: bus_rdata = reg_q;
        endcase
    end

endmodule

// File: rtl/xram_port_chk.sv
// Module: xram_port_chk
// Property checker bound into every xram_port instance. It watches the
// decoder selects, the pointer and the read data over time.
module xram_port_chk
    import xram_pkg::*;
#(
    parameter int AW    = 11,
    parameter int DEPTH = 2048
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic [7:0]    bus_rdata,
    input xsel_t         sel,
    input logic          bank_on,
    input logic          burst_on,
    input logic          dp_acc,
    input logic [AW-1:0] ptr_q
);

    // R6: a burst data-port access advances the pointer by one
    a_r6_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_acc && burst_on) |=> (ptr_q == AW'($past(ptr_q) + 1)));

    // R7: without burst, a data-port access leaves the pointer alone
    a_r7_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_acc && !burst_on) |=> $stable(ptr_q));

    // R8: stepping from the last byte lands on zero
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_acc && burst_on && ptr_q == AW'(DEPTH - 1)) |=> (ptr_q == '0));

    // R2 and R12: read data moves only after an accepted read
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_wr) |=> $stable(bus_rdata));

    // R3: the extended registers stay unselected in the base view
    a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_on |-> !(sel.extc || sel.plo || sel.phi || sel.port));

    // R11: no offset selects more than one target
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

endmodule

bind xram_port xram_port_chk #(
    .AW    (AW),
    .DEPTH (XRAM_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .sel       (sel),
    .bank_on   (bank_on),
    .burst_on  (burst_on),
    .dp_acc    (dp_acc),
    .ptr_q     (ptr_q)
);

// File: tb/xram_port_test.sv
// Bench for xram_port: a vector table walked by one loop, then directed
// tests of reset, read hold and simultaneous strobes. Inputs change on the
// falling edge; bus_rdata is sampled one falling edge after the read.
module xram_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    xram_port #(.XRAM_DEPTH(2048)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata)
    );

    // Vector: {req[3:0], is_read, offset[7:0], data_or_expected[7:0]}
    localparam int NV = 39;
    localparam logic [20:0] VEC [NV] = '{
        {4'd3,  1'b0, 8'h0A, 8'h10},  // R3 enter extended view
        {4'd3,  1'b1, 8'h0A, 8'h10},  // R3
        {4'd4,  1'b0, 8'h50, 8'h34},  // R4
        {4'd4,  1'b0, 8'h51, 8'h02},  // R4
        {4'd4,  1'b1, 8'h50, 8'h34},  // R4
        {4'd4,  1'b1, 8'h51, 8'h02},  // R4
        {4'd5,  1'b0, 8'h53, 8'hA5},  // R5 burst off
        {4'd5,  1'b1, 8'h53, 8'hA5},  // R5
        {4'd7,  1'b1, 8'h50, 8'h34},  // R7 pointer unchanged
        {4'd9,  1'b0, 8'h4A, 8'hFF},  // R9
        {4'd9,  1'b1, 8'h4A, 8'h30},  // R9 only bits 5,4 kept
        {4'd6,  1'b0, 8'h53, 8'h11},  // R6 0x234 -> 0x235
        {4'd6,  1'b0, 8'h53, 8'h22},  // R6 -> 0x236
        {4'd6,  1'b1, 8'h50, 8'h36},  // R6
        {4'd6,  1'b0, 8'h50, 8'h34},  // R6
        {4'd6,  1'b1, 8'h53, 8'h11},  // R6 read advances
        {4'd6,  1'b1, 8'h53, 8'h22},  // R6
        {4'd6,  1'b1, 8'h50, 8'h36},  // R6
        {4'd4,  1'b0, 8'h51, 8'hFF},  // R4 bits above depth dropped
        {4'd4,  1'b1, 8'h51, 8'h07},  // R4
        {4'd8,  1'b0, 8'h50, 8'hFF},  // R8 pointer 0x7FF
        {4'd8,  1'b0, 8'h53, 8'h5A},  // R8 write wraps
        {4'd8,  1'b1, 8'h50, 8'h00},  // R8
        {4'd8,  1'b1, 8'h51, 8'h00},  // R8
        {4'd8,  1'b0, 8'h50, 8'hFF},  // R8
        {4'd8,  1'b0, 8'h51, 8'h07},  // R8
        {4'd8,  1'b1, 8'h53, 8'h5A},  // R8 read wraps
        {4'd8,  1'b1, 8'h51, 8'h00},  // R8
        {4'd11, 1'b0, 8'h52, 8'h77},  // R11
        {4'd11, 1'b1, 8'h52, 8'h00},  // R11
        {4'd11, 1'b1, 8'h00, 8'h00},  // R11
        {4'd10, 1'b0, 8'h0A, 8'h00},  // R10 base view
        {4'd10, 1'b0, 8'h50, 8'h99},  // R10 general RAM
        {4'd10, 1'b1, 8'h50, 8'h99},  // R10
        {4'd10, 1'b0, 8'h0A, 8'h10},  // R10
        {4'd10, 1'b1, 8'h50, 8'h00},  // R10 pointer untouched
        {4'd10, 1'b0, 8'h0A, 8'h00},  // R10
        {4'd10, 1'b1, 8'h50, 8'h99},  // R10 general RAM untouched
        {4'd10, 1'b0, 8'h0A, 8'h10}   // R10 back to extended view
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input int req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        do_reset();
        check(1, bus_rdata, 8'h00);              // R1 read data cleared
        do_read(1, 8'h0A, 8'h00);                // R1 control register

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][16])
                do_read(int'(VEC[i][20:17]), VEC[i][15:8], VEC[i][7:0]);
            else
                do_write(VEC[i][15:8], VEC[i][7:0]);
        end

        // R12: both strobes together write and do not read
        do_read(12, 8'h0A, 8'h10);
        @(negedge clk);
        bus_addr = 8'h0A; bus_wdata = 8'h13; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check(12, bus_rdata, 8'h10);
        do_read(12, 8'h0A, 8'h13);

        // R2: read data holds across idle cycles and writes
        repeat (5) @(negedge clk);
        check(2, bus_rdata, 8'h13);
        do_write(8'h0A, 8'h10);
        check(2, bus_rdata, 8'h13);

        // R1: a second reset clears the stored state
        do_write(8'h4A, 8'h20);
        do_write(8'h50, 8'h44);
        do_reset();
        check(1, bus_rdata, 8'h00);
        do_read(1, 8'h0A, 8'h00);
        do_write(8'h0A, 8'h10);
        do_read(1, 8'h4A, 8'h00);
        do_read(1, 8'h50, 8'h00);
        do_read(1, 8'h51, 8'h00);

        finish_run();
    end

endmodule